// File: doc/BRIEF.md
# Bit-serial PCM delay line

This block holds back a bit-serial 64 kbps voice stream by a fixed number of bits, so that test equipment on either side of it behaves as it would across a satellite hop. Each frame carries one burst of eight bits. The bits are clocked in on a 2.048 MHz sample phase, and an active-low transfer gate stays low for the length of the burst. Every qualified bit clock does three things in order. It reads the bit stored at the current location and presents it as the delayed output. It writes the new input bit into that same location. It then steps the location counter by one.

The store is a one-bit-wide memory of `2**ADDR_W` locations. A binary counter walks through it and wraps. The delay is therefore exactly `2**ADDR_W` bits of stream. With `ADDR_W = 14` the store holds 16384 bits, which is about 0.256 s at 64 kbps. The default is smaller so that elaboration stays light.

A frame strobe arrives asynchronously and passes through a two-stage synchronizer. Each frame strobe re-arms a budget of eight bit clocks, and any further qualified clocks in the same frame are dropped. The location counter is brought out for debug.

Top module: `pcm_delay_line`

## Requirements
- R1: While `rst` is high and on the first edge after it, `dbg_addr` is 0 and `dout` is 0.
- R2: A bit clock is accepted only on an edge where `sample_ce` is 1, `xfer_n` is 0 and the frame budget is not used up. Each accepted clock raises `dbg_addr` by one (modulo `2**ADDR_W`) at that edge.
- R3: After `dbg_addr` reaches `2**ADDR_W - 1`, the next accepted clock sets it to 0.
- R4: At the n-th accepted clock, counting from 0 after reset, `dout` takes the `din` value of accepted clock n − `2**ADDR_W`. For n < `2**ADDR_W`, `dout` takes 0.
- R5: `dout` keeps its value on every edge that is not an accepted clock, whatever `din` does.
- R6: At most 8 clocks are accepted per frame. A ninth qualified clock moves neither `dbg_addr` nor `dout`, and it leaves the stored bits unchanged.
- R7: A rising edge on `frame_in` restores the budget of 8 through a two-flop synchronizer. A qualified clock on the first edge after `frame_in` is sampled high is still refused. Clocks from the third edge after it onward are accepted.
- R8: After reset, no clock is accepted until the first frame strobe has been seen.
- R9: Edges with `xfer_n` high, edges with `sample_ce` low, and frame strobes with no gated clock all leave `dbg_addr`, `dout` and the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_ce | input | 1 | One-cycle enable marking the bit-sample phase (2.048 MHz rate) |
| frame_in | input | 1 | 8 kHz frame strobe, asynchronous, resynchronized inside |
| xfer_n | input | 1 | Active-low transfer gate, low during the 8-bit burst |
| din | input | 1 | Serial input bit |
| dout | output | 1 | Delayed serial bit, registered |
| dbg_addr | output | ADDR_W | Current store location, for debug |

## Verification
Both `dout` and `dbg_addr` are registered, and each updates on the same rising edge that accepts a bit clock. The bench therefore drives the inputs on a falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. Stimulus that should be refused is checked at that same falling edge: the address has not moved and the output still holds its old value. The bit the refused clock could have written is checked later, when its location is read back one full store depth further on.

Frame re-arming passes through two synchronizer flops and the budget register. The bench expects a clock on the first edge after the strobe is sampled to be refused. It waits four edges before starting a burst.

// File: rtl/pcm_delay_pkg.sv
package pcm_delay_pkg;

    // Bits moved in one frame burst.
    localparam int unsigned BURST_BITS = 8;

    // One write request to the bit store.
    typedef struct packed {
        logic wr;      // accepted bit clock this cycle
        logic bit_in;  // bit to store
    } bit_req_t;

    // Budget test: true while fewer than 'limit' bits were taken this frame.
    function automatic logic budget_open(input int unsigned used, input int unsigned limit);
        return used < limit;
    endfunction

endpackage

// File: rtl/pcm_strobe_gate.sv
module pcm_strobe_gate
    import pcm_delay_pkg::*;
#(
    parameter int unsigned BURST_LEN = BURST_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_ce,
    input  logic xfer_n,
    input  logic frame_in,
    output logic accept,
    output logic frame_rise
);
    localparam int unsigned CNT_W = $clog2(BURST_LEN + 1);

    logic [2:0]       sync_q;
    logic [CNT_W-1:0] used_q;

    // Two flops for metastability, a third for edge detection.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], frame_in};
    end

    assign frame_rise = sync_q[1] & ~sync_q[2];

    assign accept = sample_ce & ~xfer_n &
                    budget_open(int'(used_q), BURST_LEN);

    // Budget starts closed so nothing is taken before the first frame.
    always_ff @(posedge clk) begin
        if (rst)             used_q <= CNT_W'(BURST_LEN);
        else if (frame_rise) used_q <= '0;
        else if (accept)     used_q <= used_q + 1'b1;
    end

endmodule

// File: rtl/pcm_addr_ctr.sv
module pcm_addr_ctr #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              filled
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            filled <= 1'b0;
        end else if (step) begin
            addr <= addr + 1'b1;
            if (addr == LAST) filled <= 1'b1;
        end
    end

endmodule

// File: rtl/pcm_bit_store.sv
module pcm_bit_store
    import pcm_delay_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_req_t          req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              filled,
    output logic              dout
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic mem [DEPTH];
    logic out_q;

    // Write port: the new bit replaces the one being read this cycle.
    always_ff @(posedge clk) begin
        if (req.wr) mem[addr] <= req.bit_in;
    end

    // Read port returns the old content; unwritten locations read as 0.
    always_ff @(posedge clk) begin
        if (rst)         out_q <= 1'b0;
        else if (req.wr) out_q <= filled ? mem[addr] : 1'b0;
    end

    assign dout = out_q;

endmodule

// File: rtl/pcm_delay_line.sv
module pcm_delay_line
    import pcm_delay_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BURST_LEN = BURST_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_ce,
    input  logic              frame_in,
    input  logic              xfer_n,
    input  logic              din,
    output logic              dout,
    output logic [ADDR_W-1:0] dbg_addr
);
    logic     accept;
    logic     frame_rise;
    logic     filled;
    bit_req_t req;

    pcm_strobe_gate #(.BURST_LEN(BURST_LEN)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .sample_ce  (sample_ce),
        .xfer_n     (xfer_n),
        .frame_in   (frame_in),
        .accept     (accept),
        .frame_rise (frame_rise)
    );

    pcm_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .step   (accept),
        .addr   (dbg_addr),
        .filled (filled)
    );

    assign req = '{wr: accept, bit_in: din};

    pcm_bit_store #(.ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .addr   (dbg_addr),
        .filled (filled),
        .dout   (dout)
    );

endmodule

// File: rtl/pcm_delay_line_chk.sv
module pcm_delay_line_chk #(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BURST_LEN = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_ce,
    input logic              xfer_n,
    input logic              accept,
    input logic              frame_rise,
    input logic              dout,
    input logic [ADDR_W-1:0] dbg_addr
);
    int   taken;
    logic seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken      <= 0;
            seen_frame <= 1'b0;
        end else begin
            if (frame_rise) begin
                taken      <= 0;
                seen_frame <= 1'b1;
            end else if (accept) begin
                taken <= taken + 1;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (dbg_addr == '0 && dout == 1'b0));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> dbg_addr == ADDR_W'($past(dbg_addr) + 1'b1));

    // R9
    gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_n || !sample_ce) |=> ($stable(dbg_addr) && $stable(dout)));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(dout));

    // R6
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        taken <= int'(BURST_LEN));

    // R8
    no_early_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_frame |-> !accept);

endmodule

bind pcm_delay_line pcm_delay_line_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_ce  (sample_ce),
    .xfer_n     (xfer_n),
    .accept     (accept),
    .frame_rise (frame_rise),
    .dout       (dout),
    .dbg_addr   (dbg_addr)
);

// File: tb/pcm_delay_line_tb.sv
`timescale 1ns/1ps
module pcm_delay_line_tb;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_ce = 1'b0;
    logic          frame_in = 1'b0;
    logic          xfer_n = 1'b1;
    logic          din = 1'b0;
    logic          dout;
    logic [AW-1:0] dbg_addr;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic        q[$];
    int          m_addr = 0;
    logic        m_dout = 1'b0;
    logic [15:0] lfsr   = 16'hACE1;

    always #2.5 clk = ~clk;

    pcm_delay_line #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sample_ce (sample_ce),
        .frame_in  (frame_in),
        .xfer_n    (xfer_n),
        .din       (din),
        .dout      (dout),
        .dbg_addr  (dbg_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic frame_pulse();
        @(negedge clk) frame_in = 1'b1;
        @(negedge clk) frame_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // One drive cycle; outputs read at the following falling edge.
    task automatic drive_bit(input logic b, input logic gate_low, input logic ce);
        @(negedge clk);
        din = b; xfer_n = ~gate_low; sample_ce = ce;
        @(negedge clk);
        sample_ce = 1'b0; xfer_n = 1'b1; din = ~b;
    endtask

    task automatic good_bit();
        logic b;
        logic exp;
        b    = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        drive_bit(b, 1'b1, 1'b1);
        exp = (q.size() == DEPTH) ? q.pop_front() : 1'b0;
        q.push_back(b);
        m_dout = exp;
        m_addr = (m_addr + 1) % DEPTH;
        check("R4 delayed bit", 32'(dout), 32'(m_dout));
        check("R2 address step", 32'(dbg_addr), 32'(m_addr));
        if (m_addr == 0) check("R3 address wrap", 32'(dbg_addr), 32'd0);
    endtask

    task automatic burst();
        frame_pulse();
        repeat (8) good_bit();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset addr", 32'(dbg_addr), 32'd0);
        check("R1 reset dout", 32'(dout), 32'd0);
    endtask

    task automatic t_no_frame();
        drive_bit(1'b1, 1'b1, 1'b1);
        check("R8 no accept before frame addr", 32'(dbg_addr), 32'd0);
        check("R8 no accept before frame dout", 32'(dout), 32'd0);
    endtask

    task automatic t_fill();
        repeat (6) burst();
    endtask

    task automatic t_hold();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) din = i[0];
        end
        @(negedge clk);
        check("R5 hold dout", 32'(dout), 32'(m_dout));
        check("R5 hold addr", 32'(dbg_addr), 32'(m_addr));
    endtask

    task automatic t_ignored();
        frame_pulse();
        for (int i = 0; i < 3; i++) begin
            drive_bit(i[0], 1'b0, 1'b1);
            check("R9 gate high addr", 32'(dbg_addr), 32'(m_addr));
            check("R9 gate high dout", 32'(dout), 32'(m_dout));
        end
        drive_bit(1'b1, 1'b1, 1'b0);
        check("R9 no sample phase addr", 32'(dbg_addr), 32'(m_addr));
        frame_pulse();
        check("R9 frame only addr", 32'(dbg_addr), 32'(m_addr));
        check("R9 frame only dout", 32'(dout), 32'(m_dout));
    endtask

    task automatic t_budget();
        repeat (8) good_bit();
        drive_bit(~m_dout, 1'b1, 1'b1);
        check("R6 ninth clock addr", 32'(dbg_addr), 32'(m_addr));
        check("R6 ninth clock dout", 32'(dout), 32'(m_dout));
    endtask

    task automatic t_rearm();
        @(negedge clk) frame_in = 1'b1;
        @(negedge clk);
        frame_in = 1'b0; din = 1'b1; xfer_n = 1'b0; sample_ce = 1'b1;
        @(negedge clk);
        sample_ce = 1'b0; xfer_n = 1'b1;
        check("R7 early clock refused", 32'(dbg_addr), 32'(m_addr));
        repeat (3) @(negedge clk);
        repeat (8) good_bit();
    endtask

    task automatic t_long();
        repeat (14) burst();
    endtask

    initial begin
        t_reset();
        t_no_frame();
        t_fill();
        t_hold();
        t_ignored();
        t_budget();
        t_rearm();
        t_long();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule